// File: doc/BRIEF.md
# Centralized Scoreboard Hazard Controller

This block is the central hazard-tracking controller for a small pipeline that issues instructions in order and lets them finish out of order. One table, held in a single place, keeps a status entry for each functional unit and a pending-writer entry for each architectural register. Each instruction passes through four steps in a fixed order: issue, operand read, execution, and write-back. The controller grants each step only when no hazard blocks it.

A decoded instruction arrives with an operation code, a destination register, two source registers and the index of the unit it needs. The controller either accepts the instruction with a one-hot issue grant or raises a stall toward fetch. Each unit entry records its producer tags and its source-ready flags. Because of this, a read-after-write hazard holds the instruction at operand read, a write-after-read hazard holds it at write-back, and a write-after-write or structural hazard holds it at issue. The units report the end of execution with one completion pulse each. The datapath and the register file are outside this block. It provides only the grants, the destination register of the current write-back, and the operation each unit holds.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset every unit is idle and no register has a pending writer. While reset is applied and on the first cycle after it, no read or write-back grant is asserted. Any instruction presented next issues without a stall.
- R2: When the requested unit is idle and the destination register has no pending writer, the instruction issues in the same cycle. `issue_grant` is one-hot on the requested unit and `stall` is low. Unit indices are 0 = integer (1-cycle latency), 1 = add (2 cycles) and 2 = multiply (4 cycles).
- R3: An instruction whose unit is busy is stalled and not granted. A unit that has just issued cannot issue again on the next cycle.
- R4: An instruction whose destination register already has a pending writer is stalled until that writer completes write-back.
- R5: A unit is granted operand read only when neither source is still awaited from a producing unit. A consumer reads on the cycle after its producer's write-back.
- R6: Operand read is granted for exactly one cycle per instruction. A completion pulse moves the unit from execution to write-back.
- R7: A finished unit does not write back while another unit has its destination register as a source that is ready but not yet read. It writes back on the cycle after that read.
- R8: At most one write-back is granted per cycle. Among the units ready to write, the lowest-numbered one wins. `wb_dst` carries the destination register of the granted unit.
- R9: Write-back frees the unit and clears the register's pending writer, so a stalled instruction waiting on either one issues on the next cycle. A unit that has written back cannot write back again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | A decoded instruction is presented |
| instr_op | input | 4 | Operation code, stored with the unit |
| instr_fu | input | 2 | Requested unit index (0 integer, 1 add, 2 multiply) |
| instr_dst | input | 3 | Destination register |
| instr_src1 | input | 3 | First source register |
| instr_src2 | input | 3 | Second source register |
| exec_done | input | 3 | Per-unit end-of-execution pulse |
| stall | output | 1 | Presented instruction cannot issue this cycle |
| issue_grant | output | 3 | One-hot: instruction accepted into this unit |
| read_grant | output | 3 | Per-unit permission to read operands |
| wb_grant | output | 3 | One-hot write-back permission |
| wb_dst | output | 3 | Destination register of the granted write-back |
| fu_op | output | 12 | Operation held by each unit, 4 bits per unit, unit 0 lowest |

## Verification
The properties assume that the instruction inputs stay stable while `stall` is high. They also assume that `exec_done` pulses for a unit only after that unit's read grant, and once per instruction. The bench holds each instruction until it is accepted. A unit model raises each unit's completion pulse exactly its latency after the read grant it observed, and never otherwise. The programs use only unit indices 0 to 2. Each program is drained before the next one starts, so the expected write-back order and the exact stall and grant cycles can be derived by hand.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_FU  = 3;
    localparam int NUM_REG = 8;
    localparam int OP_W    = 4;
    localparam int FU_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1;
    localparam int REG_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_EXEC  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [OP_W-1:0]    op;
        logic [REG_W-1:0]   dst;
        logic [REG_W-1:0]   src_a;
        logic [REG_W-1:0]   src_b;
        logic               wait_a;
        logic               wait_b;
        logic [FU_W-1:0]    prod_a;
        logic [FU_W-1:0]    prod_b;
        logic               rdy_a;
        logic               rdy_b;
    } unit_entry_t;

    typedef struct packed {
        logic               pend;
        logic [FU_W-1:0]    owner;
    } reg_owner_t;

    typedef struct packed {
        unit_entry_t [NUM_FU-1:0]  unit;
        reg_owner_t  [NUM_REG-1:0] regs;
    } sb_state_t;
endpackage

// File: rtl/sb_issue_gate.sv
module sb_issue_gate
    import sb_pkg::*;
(
    input  logic               instr_valid,
    input  logic [FU_W-1:0]    instr_fu,
    input  logic [REG_W-1:0]   instr_dst,
    input  logic [NUM_FU-1:0]  unit_busy,
    input  logic [NUM_REG-1:0] reg_pend,
    output logic               stall,
    output logic [NUM_FU-1:0]  issue_grant
);
    logic sel_busy;
    logic dst_pend;

    // Out-of-range unit indices look busy and are never granted.
    always_comb begin
        sel_busy = 1'b1;
        for (int f = 0; f < NUM_FU; f++) begin
            if (instr_fu == FU_W'(f)) begin
                sel_busy = unit_busy[f];
            end
        end
    end

    assign dst_pend = reg_pend[instr_dst];
    assign stall    = instr_valid && (sel_busy || dst_pend);

    for (genvar f = 0; f < NUM_FU; f++) begin : g_grant
        assign issue_grant[f] = instr_valid && !stall && (instr_fu == FU_W'(f));
    end
endmodule

// File: rtl/sb_wb_select.sv
module sb_wb_select
    import sb_pkg::*;
(
    input  logic [NUM_FU-1:0]             at_write,
    input  logic [NUM_FU-1:0]             at_read,
    input  logic [NUM_FU-1:0][REG_W-1:0]  dst,
    input  logic [NUM_FU-1:0][REG_W-1:0]  src_a,
    input  logic [NUM_FU-1:0][REG_W-1:0]  src_b,
    input  logic [NUM_FU-1:0]             rdy_a,
    input  logic [NUM_FU-1:0]             rdy_b,
    output logic [NUM_FU-1:0]             wb_grant,
    output logic                          wb_any,
    output logic [FU_W-1:0]               wb_fu,
    output logic [REG_W-1:0]              wb_dst
);
    logic [NUM_FU-1:0] war_hold;
    logic [NUM_FU-1:0] cand;

    for (genvar f = 0; f < NUM_FU; f++) begin : g_war
        always_comb begin
            war_hold[f] = 1'b0;
            for (int g = 0; g < NUM_FU; g++) begin
                if (g != f && at_read[g]) begin
                    if ((rdy_a[g] && src_a[g] == dst[f]) ||
                        (rdy_b[g] && src_b[g] == dst[f])) begin
                        war_hold[f] = 1'b1;
                    end
                end
            end
        end
        assign cand[f] = at_write[f] && !war_hold[f];
    end

    // Fixed priority: the lowest-numbered candidate wins.
    always_comb begin
        wb_grant = '0;
        wb_any   = 1'b0;
        wb_fu    = '0;
        wb_dst   = '0;
        for (int f = NUM_FU - 1; f >= 0; f--) begin
            if (cand[f]) begin
                wb_grant = '0;
                wb_grant[f] = 1'b1;
                wb_any   = 1'b1;
                wb_fu    = FU_W'(f);
                wb_dst   = dst[f];
            end
        end
    end
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
    import sb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    instr_valid,
    input  logic [OP_W-1:0]         instr_op,
    input  logic [FU_W-1:0]         instr_fu,
    input  logic [REG_W-1:0]        instr_dst,
    input  logic [REG_W-1:0]        instr_src1,
    input  logic [REG_W-1:0]        instr_src2,
    input  logic [NUM_FU-1:0]       exec_done,
    output logic                    stall,
    output logic [NUM_FU-1:0]       issue_grant,
    output logic [NUM_FU-1:0]       read_grant,
    output logic [NUM_FU-1:0]       wb_grant,
    output logic [REG_W-1:0]        wb_dst,
    output logic [NUM_FU*OP_W-1:0]  fu_op
);
    sb_state_t st_q, st_d;

    logic [NUM_FU-1:0]             unit_busy, at_read, at_write, rdy_a, rdy_b;
    logic [NUM_FU-1:0][REG_W-1:0]  u_dst, u_src_a, u_src_b;
    logic [NUM_REG-1:0]            reg_pend;
    logic                          wb_any;
    logic [FU_W-1:0]               wb_fu;

    for (genvar f = 0; f < NUM_FU; f++) begin : g_view
        assign unit_busy[f]  = st_q.unit[f].phase != PH_IDLE;
        assign at_read[f]    = st_q.unit[f].phase == PH_READ;
        assign at_write[f]   = st_q.unit[f].phase == PH_WRITE;
        assign rdy_a[f]      = st_q.unit[f].rdy_a;
        assign rdy_b[f]      = st_q.unit[f].rdy_b;
        assign u_dst[f]      = st_q.unit[f].dst;
        assign u_src_a[f]    = st_q.unit[f].src_a;
        assign u_src_b[f]    = st_q.unit[f].src_b;
        assign read_grant[f] = at_read[f] && rdy_a[f] && rdy_b[f];
        assign fu_op[f*OP_W +: OP_W] = st_q.unit[f].op;
    end

    for (genvar r = 0; r < NUM_REG; r++) begin : g_regs
        assign reg_pend[r] = st_q.regs[r].pend;
    end

    sb_issue_gate u_issue (
        .instr_valid (instr_valid),
        .instr_fu    (instr_fu),
        .instr_dst   (instr_dst),
        .unit_busy   (unit_busy),
        .reg_pend    (reg_pend),
        .stall       (stall),
        .issue_grant (issue_grant)
    );

    sb_wb_select u_wb (
        .at_write (at_write),
        .at_read  (at_read),
        .dst      (u_dst),
        .src_a    (u_src_a),
        .src_b    (u_src_b),
        .rdy_a    (rdy_a),
        .rdy_b    (rdy_b),
        .wb_grant (wb_grant),
        .wb_any   (wb_any),
        .wb_fu    (wb_fu),
        .wb_dst   (wb_dst)
    );

    reg_owner_t own_a, own_b;
    logic       hold_a, hold_b;

    // A source is still awaited unless its writer finishes this very cycle.
    always_comb begin
        own_a  = st_q.regs[instr_src1];
        own_b  = st_q.regs[instr_src2];
        hold_a = own_a.pend && !(wb_any && wb_fu == own_a.owner);
        hold_b = own_b.pend && !(wb_any && wb_fu == own_b.owner);
    end

    always_comb begin
        st_d = st_q;

        // Write-back: wake consumers, free the unit, clear the register owner.
        if (wb_any) begin
            for (int g = 0; g < NUM_FU; g++) begin
                if (st_q.unit[g].wait_a && st_q.unit[g].prod_a == wb_fu) begin
                    st_d.unit[g].wait_a = 1'b0;
                    st_d.unit[g].rdy_a  = 1'b1;
                end
                if (st_q.unit[g].wait_b && st_q.unit[g].prod_b == wb_fu) begin
                    st_d.unit[g].wait_b = 1'b0;
                    st_d.unit[g].rdy_b  = 1'b1;
                end
            end
            st_d.regs[wb_dst].pend = 1'b0;
        end

        for (int f = 0; f < NUM_FU; f++) begin
            if (wb_grant[f]) begin
                st_d.unit[f].phase = PH_IDLE;
            end else if (read_grant[f]) begin
                st_d.unit[f].phase = PH_EXEC;
                st_d.unit[f].rdy_a = 1'b0;
                st_d.unit[f].rdy_b = 1'b0;
            end else if (st_q.unit[f].phase == PH_EXEC && exec_done[f]) begin
                st_d.unit[f].phase = PH_WRITE;
            end

            if (issue_grant[f]) begin
                st_d.unit[f].phase  = PH_READ;
                st_d.unit[f].op     = instr_op;
                st_d.unit[f].dst    = instr_dst;
                st_d.unit[f].src_a  = instr_src1;
                st_d.unit[f].src_b  = instr_src2;
                st_d.unit[f].wait_a = hold_a;
                st_d.unit[f].wait_b = hold_b;
                st_d.unit[f].prod_a = own_a.owner;
                st_d.unit[f].prod_b = own_b.owner;
                st_d.unit[f].rdy_a  = !hold_a;
                st_d.unit[f].rdy_b  = !hold_b;
                st_d.regs[instr_dst].pend  = 1'b1;
                st_d.regs[instr_dst].owner = FU_W'(f);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
module sb_hazard_ctrl_chk
    import sb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_FU-1:0] issue_grant,
    input logic [NUM_FU-1:0] read_grant,
    input logic [NUM_FU-1:0] wb_grant
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (read_grant == '0 && wb_grant == '0));

    // R8
    single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));

    for (genvar f = 0; f < NUM_FU; f++) begin : g_unit
        // R3
        busy_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
            issue_grant[f] |=> !issue_grant[f]);

        // R6
        one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            read_grant[f] |=> !read_grant[f]);

        // R9
        one_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[f] |=> !wb_grant[f]);
    end
endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_grant (issue_grant),
    .read_grant  (read_grant),
    .wb_grant    (wb_grant)
);

// File: tb/tb_sb_hazard_ctrl.sv
module tb_sb_hazard_ctrl;
    localparam int NFU = 3;
    localparam int LAT [NFU] = '{1, 2, 4};
    localparam int FU_INT = 0, FU_ADD = 1, FU_MUL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [3:0]  instr_op = '0;
    logic [1:0]  instr_fu = '0;
    logic [2:0]  instr_dst = '0, instr_src1 = '0, instr_src2 = '0;
    logic [2:0]  exec_done = '0;
    logic        stall;
    logic [2:0]  issue_grant, read_grant, wb_grant, wb_dst;
    logic [11:0] fu_op;

    sb_hazard_ctrl dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_fu(instr_fu), .instr_dst(instr_dst), .instr_src1(instr_src1),
        .instr_src2(instr_src2), .exec_done(exec_done), .stall(stall),
        .issue_grant(issue_grant), .read_grant(read_grant), .wb_grant(wb_grant),
        .wb_dst(wb_dst), .fu_op(fu_op)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int timer [NFU] = '{0, 0, 0};
    int rd_cyc [NFU] = '{0, 0, 0};
    int wb_cyc [NFU] = '{0, 0, 0};
    logic [7:0] exp_q [$];
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            chk(1'b0, "watchdog", cyc, 0);
            finish_run();
        end
    end

    // Unit model: completion pulse exactly LAT cycles after an observed read grant.
    always @(negedge clk) begin
        for (int f = 0; f < NFU; f++) begin
            exec_done[f] <= 1'b0;
            if (timer[f] != 0) begin
                timer[f] = timer[f] - 1;
                if (timer[f] == 0) exec_done[f] <= 1'b1;
            end
            if (rst_n && read_grant[f]) timer[f] = LAT[f];
        end
    end

    // Monitor: pops expected write-backs in order.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int f = 0; f < NFU; f++) if (read_grant[f]) rd_cyc[f] = cyc;
            if (wb_grant != '0) begin
                chk($countones(wb_grant) == 1, "R8 one-hot wb", int'(wb_grant), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected wb", int'(wb_grant), 0);
                end else begin
                    logic [7:0] it;
                    it = exp_q.pop_front();
                    chk(wb_grant == (3'b1 << it[7:4]), "R8 wb unit order",
                        int'(wb_grant), int'(3'b1 << it[7:4]));
                    chk(wb_dst == it[2:0], "R8 wb_dst", int'(wb_dst), int'(it[2:0]));
                end
                for (int f = 0; f < NFU; f++) if (wb_grant[f]) wb_cyc[f] = cyc;
            end
        end
    end

    task automatic expect_wb(input int fu, input int dst);
        exp_q.push_back({4'(fu), 1'b0, 3'(dst)});
    endtask

    // Called at a negedge; returns at the negedge after acceptance.
    task automatic issue(input int fu, input int dst, input int s1, input int s2,
                         input int exp_stalls, input string req);
        int n;
        n = 0;
        instr_valid = 1'b1;
        instr_fu    = 2'(fu);
        instr_dst   = 3'(dst);
        instr_src1  = 3'(s1);
        instr_src2  = 3'(s2);
        instr_op    = 4'(fu + dst);
        #1;
        while (stall) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(issue_grant == (3'b1 << fu), "R2 issue one-hot", int'(issue_grant), int'(3'b1 << fu));
        if (exp_stalls >= 0) chk(n == exp_stalls, req, n, exp_stalls);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(stall == 1'b0, "R9 idle after drain", int'(stall), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1 during reset
        chk(read_grant == '0, "R1 read idle in reset", int'(read_grant), 0);
        chk(wb_grant == '0, "R1 wb idle in reset", int'(wb_grant), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(read_grant == '0 && wb_grant == '0, "R1 quiet after reset",
            int'({read_grant, wb_grant}), 0);
        chk(stall == 1'b0 && issue_grant == '0, "R1 no stall idle", int'(stall), 0);

        // Independent instructions: R2 and R8 order by latency.
        expect_wb(FU_INT, 1); expect_wb(FU_ADD, 6); expect_wb(FU_MUL, 4);
        issue(FU_INT, 1, 2, 3, 0, "R1 first issue no stall");
        issue(FU_MUL, 4, 5, 6, 0, "R2 no stall mul");
        issue(FU_ADD, 6, 7, 0, 0, "R2 no stall add");
        drain();

        // Structural hazard: R3 and R9 exact stall length.
        expect_wb(FU_MUL, 1); expect_wb(FU_MUL, 2);
        issue(FU_MUL, 1, 0, 0, 0, "R3 first mul");
        issue(FU_MUL, 2, 3, 3, 6, "R3 R9 busy-unit stall cycles");
        drain();

        // WAW hazard: R4.
        expect_wb(FU_MUL, 3); expect_wb(FU_ADD, 3);
        issue(FU_MUL, 3, 1, 2, 0, "R4 first writer");
        issue(FU_ADD, 3, 4, 5, 6, "R4 same-destination stall cycles");
        drain();

        // RAW + WAR: mul r2; add r3 <- r2,r5; int r5.
        expect_wb(FU_MUL, 2); expect_wb(FU_INT, 5); expect_wb(FU_ADD, 3);
        issue(FU_MUL, 2, 1, 1, 0, "R5 producer");
        issue(FU_ADD, 3, 2, 5, 0, "R5 consumer issues");
        issue(FU_INT, 5, 6, 7, 0, "R7 later writer issues");
        drain();
        chk(rd_cyc[FU_ADD] - wb_cyc[FU_MUL] == 1, "R5 read after producer wb",
            rd_cyc[FU_ADD] - wb_cyc[FU_MUL], 1);
        chk(wb_cyc[FU_INT] - rd_cyc[FU_ADD] == 1, "R7 wb after pending read",
            wb_cyc[FU_INT] - rd_cyc[FU_ADD], 1);

        // Same-cycle finish: R8 lowest unit first.
        expect_wb(FU_INT, 4); expect_wb(FU_ADD, 1);
        issue(FU_ADD, 1, 2, 3, 0, "R8 add");
        issue(FU_INT, 4, 5, 6, 0, "R8 int");
        drain();
        chk(wb_cyc[FU_ADD] - wb_cyc[FU_INT] == 1, "R8 loser one cycle later",
            wb_cyc[FU_ADD] - wb_cyc[FU_INT], 1);

        // R6: single read per instruction, op visible on the unit.
        expect_wb(FU_ADD, 7);
        issue(FU_ADD, 7, 1, 2, 0, "R6 issue");
        chk(read_grant == 3'b010, "R6 read grant on add", int'(read_grant), 2);
        chk(fu_op[7:4] == 4'(FU_ADD + 7), "R6 op held by unit", int'(fu_op[7:4]), FU_ADD + 7);
        @(negedge clk);
        chk(read_grant == 3'b000, "R6 read lasts one cycle", int'(read_grant), 0);
        drain();

        finish_run();
    end
endmodule